// File: doc/BRIEF.md
# Power-On Serial Configuration Exchanger

This block sits on a board and takes part in a single configuration exchange with a far-end controller over a two-wire synchronous link: a serial input it samples and a serial output it drives, both timed by the link clock. Once the power-on reset is released it counts link clock edges. On fixed edges it captures bits from the serial input into staging: a through-control field, one test-chip enable bit, a clock-select field and ten active-low header switch settings. On overlapping edges it presents the board build strap, the logic identification value and a power-good flag on the serial output.

The captured settings reach the configuration outputs together, in one step, after the last bit has arrived. A half-shifted value therefore never drives a switch or a clock multiplexer. After that the block parks with both directions quiet and ignores the serial input. While parked, it raises a hand-over flag whenever system reset is released. A mode pin suspends the exchange: while the pin is high, the count does not move and nothing is captured or sent. A fresh power-on reset restarts the whole sequence.

Top module: `pwrup_cfg_xchg`

## Requirements
- R1: While `por_n` is low, `sdo` is low, no serial bit is captured and the outputs sit at their defaults: `zctl_o`=0, `tc_oe_o`=0, `clksel_o`=0 and every switch output high (open).
- R2: Cycle 0 is the first rising `lclk` edge with `por_n` high. On that edge `sdi` is ignored and `sdo` is low.
- R3: On cycles 1 to 4, `sdi` supplies `zctl_o` bits 3 down to 0, in that order. During the same cycles `sdo` shows `board_id_i` bits 3 down to 0.
- R4: On cycle 5, `sdi` supplies the test-chip enable, which drives all six `tc_oe_o` bits to the same value. During that cycle `sdo` shows `logic_id_i[3]`.
- R5: On cycles 6 to 10, `sdi` supplies `clksel_o` bits 4 down to 0. `sdo` shows `logic_id_i` bits 2 down to 0 on cycles 6 to 8, `pgood_i` on cycle 9 and low on cycle 10.
- R6: On cycles 11 to 20, `sdi` supplies the active-low switch bits in this order: `x_thru_n_o[1]`, `x_thru_n_o[0]`, `x_fold_n_o[1]`, `x_fold_n_o[0]`, `y_thru_n_o[1]`, `y_thru_n_o[0]`, `y_fold_n_o[1]`, `y_fold_n_o[0]`, `z_thru_n_o`, `z_fold_n_o`.
- R7: All configuration outputs take their captured values together, on the cycle 21 edge. Before that edge they keep their previous values.
- R8: From cycle 21 on, `sdo` is low. After cycle 21 the block is parked: `sdi` is ignored and the outputs hold until `por_n` goes low again.
- R9: While `mode_i` is high, the cycle count holds, `sdo` is low and `sdi` is not captured. When `mode_i` returns low, the exchange resumes at the cycle where it stopped.
- R10: `handoff_o` is high exactly when the block is parked and `sys_rst_n` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| lclk | input | 1 | Link clock; all state changes on its rising edge |
| por_n | input | 1 | Power-on reset, active low, synchronous |
| sys_rst_n | input | 1 | System reset, active low; its release permits hand-over once parked |
| mode_i | input | 1 | Low: exchange runs; high: exchange suspended |
| sdi | input | 1 | Serial configuration bits from the far end |
| board_id_i | input | 4 | Board build strap value |
| logic_id_i | input | 4 | Identification value of this logic |
| pgood_i | input | 1 | Power-good status |
| sdo | output | 1 | Serial status bits to the far end |
| zctl_o | output | 4 | Through-control setting |
| tc_oe_o | output | 6 | Test-chip bus output enables (all equal) |
| clksel_o | output | 5 | Clock-select setting |
| x_thru_n_o | output | 2 | X header through switches, active low |
| x_fold_n_o | output | 2 | X header fold switches, active low |
| y_thru_n_o | output | 2 | Y header through switches, active low |
| y_fold_n_o | output | 2 | Y header fold switches, active low |
| z_thru_n_o | output | 1 | Z header through switch, active low |
| z_fold_n_o | output | 1 | Z header fold switch, active low |
| handoff_o | output | 1 | Parked and system reset released |

## Verification
On cycles 1 to 9 the block both captures a configuration bit and drives a status bit on every edge. The bench loads the strap and identification inputs with patterns that differ from the `sdi` stream, so a swapped wire, an off-by-one index or a reversed bit order shows up as a field mismatch. It checks `sdo` on each of these cycles and every output field after the commit edge. A mode suspension is also placed in the middle of this overlap. During it the bench toggles `sdi` and requires `sdo` to stay low, then requires the resumed stream to land in the correct fields.

// File: rtl/pwrup_cfg_pkg.sv
`timescale 1ns/1ps
// Package: shared field widths, derived cycle positions and the
// configuration record for the power-on configuration exchanger.
// Assumes every serial field arrives MSB first, in the record's declared order.
package pwrup_cfg_pkg;

    localparam int ZCTL_W   = 4;   // through-control field width
    localparam int TCOE_N   = 6;   // number of test-chip output enables
    localparam int CLKSEL_W = 5;   // clock-select field width
    localparam int XSW_W    = 2;   // X header switches per kind
    localparam int YSW_W    = 2;   // Y header switches per kind
    localparam int ID_W     = 4;   // board and logic identification width

    localparam int SW_N       = 2 * XSW_W + 2 * YSW_W + 2;
    localparam int RX_N       = ZCTL_W + 1 + CLKSEL_W + SW_N;
    localparam int RX_FIRST   = 1;
    localparam int RX_LAST    = RX_N;
    localparam int COMMIT_CYC = RX_LAST + 1;
    localparam int PARK_CYC   = RX_LAST + 2;
    localparam int TX_PG_CYC  = 2 * ID_W + 1;
    localparam int CNT_W      = $clog2(PARK_CYC + 1);

    // Packed record: the first declared member is the first received bit.
    typedef struct packed {
        logic [ZCTL_W-1:0]   zctl;
        logic                tc_en;
        logic [CLKSEL_W-1:0] clksel;
        logic [XSW_W-1:0]    x_thru_n;
        logic [XSW_W-1:0]    x_fold_n;
        logic [YSW_W-1:0]    y_thru_n;
        logic [YSW_W-1:0]    y_fold_n;
        logic                z_thru_n;
        logic                z_fold_n;
    } cfg_t;

    // Safe state: nothing enabled, switches open.
    localparam cfg_t CFG_DEFAULT = '{
        zctl:     '0,
        tc_en:    1'b0,
        clksel:   '0,
        x_thru_n: '1,
        x_fold_n: '1,
        y_thru_n: '1,
        y_fold_n: '1,
        z_thru_n: 1'b1,
        z_fold_n: 1'b1
    };

endpackage

// File: rtl/pwrup_cfg_seq.sv
`timescale 1ns/1ps
// Module: cycle sequencer. Counts link clock edges from power-on reset
// release, stops at the park count, and decodes the capture and commit
// windows. Assumes por_n is synchronous to lclk; mode_i high freezes the count.
module pwrup_cfg_seq
    import pwrup_cfg_pkg::*;
(
    input  logic             lclk,
    input  logic             por_n,
    input  logic             mode_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             sample_o,
    output logic             commit_o,
    output logic             parked_o
);

    localparam logic [CNT_W-1:0] FIRST_C  = CNT_W'(RX_FIRST);
    localparam logic [CNT_W-1:0] LAST_C   = CNT_W'(RX_LAST);
    localparam logic [CNT_W-1:0] COMMIT_C = CNT_W'(COMMIT_CYC);
    localparam logic [CNT_W-1:0] PARK_C   = CNT_W'(PARK_CYC);

    logic [CNT_W-1:0] cnt_q;
    logic             run;

    // Advance the cycle count while running and not yet parked.
    always_ff @(posedge lclk) begin
        if (!por_n) begin
            cnt_q <= '0;
        end else if (!mode_i && (cnt_q != PARK_C)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Decode the capture window, the commit edge and the park state.
    always_comb begin
        run      = por_n && !mode_i;
        sample_o = run && (cnt_q >= FIRST_C) && (cnt_q <= LAST_C);
        commit_o = run && (cnt_q == COMMIT_C);
        parked_o = (cnt_q == PARK_C);
    end

    assign cnt_o = cnt_q;

endmodule

// File: rtl/pwrup_cfg_rx.sv
`timescale 1ns/1ps
// Module: receive path. Shifts serial input bits into a staging register
// during the capture window and copies the whole staging register into the
// configuration record on the commit edge. Assumes bits arrive MSB first in
// record order; the record is reset to the safe default by por_n.
module pwrup_cfg_rx
    import pwrup_cfg_pkg::*;
(
    input  logic lclk,
    input  logic por_n,
    input  logic sample_i,
    input  logic commit_i,
    input  logic sdi,
    output cfg_t cfg_o
);

    logic [RX_N-1:0] stage_q;
    cfg_t            cfg_q;

    // Shift one captured bit into the staging register per capture cycle.
    always_ff @(posedge lclk) begin
        if (!por_n) begin
            stage_q <= '0;
        end else if (sample_i) begin
            stage_q <= {stage_q[RX_N-2:0], sdi};
        end
    end

    // Publish the complete staging register in one step.
    always_ff @(posedge lclk) begin
        if (!por_n) begin
            cfg_q <= CFG_DEFAULT;
        end else if (commit_i) begin
            cfg_q <= cfg_t'(stage_q);
        end
    end

    assign cfg_o = cfg_q;

endmodule

// File: rtl/pwrup_cfg_tx.sv
`timescale 1ns/1ps
// Module: transmit path. Selects the status bit for the current cycle:
// board strap MSB first, then logic identification MSB first, then power-good.
// Assumes the count is held at zero in reset; unassigned cycles give low.
module pwrup_cfg_tx
    import pwrup_cfg_pkg::*;
(
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             mode_i,
    input  logic [ID_W-1:0]  board_id_i,
    input  logic [ID_W-1:0]  logic_id_i,
    input  logic             pgood_i,
    output logic             sdo
);

    localparam logic [CNT_W-1:0] PG_C = CNT_W'(TX_PG_CYC);

    logic sdo_d;

    // Pick the status bit that belongs to the current cycle.
    always_comb begin
        sdo_d = 1'b0;
        for (int i = 0; i < ID_W; i++) begin
            if (cnt_i == CNT_W'(ID_W - i)) begin
                sdo_d = board_id_i[i];
            end
            if (cnt_i == CNT_W'(2 * ID_W - i)) begin
                sdo_d = logic_id_i[i];
            end
        end
        if (cnt_i == PG_C) begin
            sdo_d = pgood_i;
        end
        if (mode_i) begin
            sdo_d = 1'b0;
        end
    end

    assign sdo = sdo_d;

endmodule

// File: rtl/pwrup_cfg_xchg.sv
`timescale 1ns/1ps
// Module: top of the power-on configuration exchanger. Joins the sequencer,
// the receive path and the transmit path, fans the test-chip enable out to
// every output enable and flags hand-over once parked with system reset released.
// Assumes all inputs are synchronous to lclk or static straps.
module pwrup_cfg_xchg
    import pwrup_cfg_pkg::*;
(
    input  logic                lclk,
    input  logic                por_n,
    input  logic                sys_rst_n,
    input  logic                mode_i,
    input  logic                sdi,
    input  logic [ID_W-1:0]     board_id_i,
    input  logic [ID_W-1:0]     logic_id_i,
    input  logic                pgood_i,
    output logic                sdo,
    output logic [ZCTL_W-1:0]   zctl_o,
    output logic [TCOE_N-1:0]   tc_oe_o,
    output logic [CLKSEL_W-1:0] clksel_o,
    output logic [XSW_W-1:0]    x_thru_n_o,
    output logic [XSW_W-1:0]    x_fold_n_o,
    output logic [YSW_W-1:0]    y_thru_n_o,
    output logic [YSW_W-1:0]    y_fold_n_o,
    output logic                z_thru_n_o,
    output logic                z_fold_n_o,
    output logic                handoff_o
);

    logic [CNT_W-1:0] seq_cnt;
    logic             seq_sample;
    logic             seq_commit;
    logic             seq_parked;
    cfg_t             cfg_q;

    pwrup_cfg_seq u_seq (
        .lclk     (lclk),
        .por_n    (por_n),
        .mode_i   (mode_i),
        .cnt_o    (seq_cnt),
        .sample_o (seq_sample),
        .commit_o (seq_commit),
        .parked_o (seq_parked)
    );

    pwrup_cfg_rx u_rx (
        .lclk     (lclk),
        .por_n    (por_n),
        .sample_i (seq_sample),
        .commit_i (seq_commit),
        .sdi      (sdi),
        .cfg_o    (cfg_q)
    );

    pwrup_cfg_tx u_tx (
        .cnt_i      (seq_cnt),
        .mode_i     (mode_i),
        .board_id_i (board_id_i),
        .logic_id_i (logic_id_i),
        .pgood_i    (pgood_i),
        .sdo        (sdo)
    );

    // Drive every test-chip output enable from the single captured bit.
    for (genvar g = 0; g < TCOE_N; g++) begin : g_tc_oe
        assign tc_oe_o[g] = cfg_q.tc_en;
    end

    assign zctl_o     = cfg_q.zctl;
    assign clksel_o   = cfg_q.clksel;
    assign x_thru_n_o = cfg_q.x_thru_n;
    assign x_fold_n_o = cfg_q.x_fold_n;
    assign y_thru_n_o = cfg_q.y_thru_n;
    assign y_fold_n_o = cfg_q.y_fold_n;
    assign z_thru_n_o = cfg_q.z_thru_n;
    assign z_fold_n_o = cfg_q.z_fold_n;

    assign handoff_o = seq_parked && sys_rst_n;

endmodule

// File: rtl/pwrup_cfg_chk.sv
`timescale 1ns/1ps
// Module: protocol checker bound to the exchanger top. Observes the
// sequencer state, the record and the serial output; drives nothing.
module pwrup_cfg_chk
    import pwrup_cfg_pkg::*;
(
    input logic             lclk,
    input logic             por_n,
    input logic             mode_i,
    input logic             sdo,
    input logic [CNT_W-1:0] cnt,
    input logic             parked,
    input logic             commit,
    input cfg_t             cfg,
    input logic             handoff_o
);

    // R1
    rst_quiet_chk: assert property (@(posedge lclk) !por_n |=> !sdo);

    // R2
    step_chk: assert property (@(posedge lclk) disable iff (!por_n)
        (!mode_i && !parked) |=> (cnt == $past(cnt) + 1'b1));

    // R7
    cfg_hold_chk: assert property (@(posedge lclk) disable iff (!por_n)
        !commit |=> $stable(cfg));

    // R8
    park_quiet_chk: assert property (@(posedge lclk) disable iff (!por_n)
        parked |-> !sdo);

    // R8
    park_sticky_chk: assert property (@(posedge lclk) disable iff (!por_n)
        parked |=> parked);

    // R9
    pause_hold_chk: assert property (@(posedge lclk) disable iff (!por_n)
        mode_i |=> $stable(cnt));

    // R10
    handoff_chk: assert property (@(posedge lclk) disable iff (!por_n)
        handoff_o |-> parked);

endmodule

bind pwrup_cfg_xchg pwrup_cfg_chk u_chk (
    .lclk      (lclk),
    .por_n     (por_n),
    .mode_i    (mode_i),
    .sdo       (sdo),
    .cnt       (seq_cnt),
    .parked    (seq_parked),
    .commit    (seq_commit),
    .cfg       (cfg_q),
    .handoff_o (handoff_o)
);

// File: tb/tb_pwrup_cfg_xchg.sv
`timescale 1ns/1ps
// Directed bench for the power-on configuration exchanger.
module tb_pwrup_cfg_xchg;

    logic       lclk = 1'b0;
    logic       por_n = 1'b0;
    logic       sys_rst_n = 1'b0;
    logic       mode_i = 1'b0;
    logic       sdi = 1'b0;
    logic [3:0] board_id_i = 4'h0;
    logic [3:0] logic_id_i = 4'h0;
    logic       pgood_i = 1'b0;
    logic       sdo;
    logic [3:0] zctl_o;
    logic [5:0] tc_oe_o;
    logic [4:0] clksel_o;
    logic [1:0] x_thru_n_o, x_fold_n_o, y_thru_n_o, y_fold_n_o;
    logic       z_thru_n_o, z_fold_n_o;
    logic       handoff_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    localparam logic [24:0] DEF_CFG = {4'h0, 6'h00, 5'h00, 10'h3FF};

    always #2.5 lclk = ~lclk;

    pwrup_cfg_xchg dut (
        .lclk(lclk), .por_n(por_n), .sys_rst_n(sys_rst_n), .mode_i(mode_i),
        .sdi(sdi), .board_id_i(board_id_i), .logic_id_i(logic_id_i),
        .pgood_i(pgood_i), .sdo(sdo), .zctl_o(zctl_o), .tc_oe_o(tc_oe_o),
        .clksel_o(clksel_o), .x_thru_n_o(x_thru_n_o), .x_fold_n_o(x_fold_n_o),
        .y_thru_n_o(y_thru_n_o), .y_fold_n_o(y_fold_n_o),
        .z_thru_n_o(z_thru_n_o), .z_fold_n_o(z_fold_n_o), .handoff_o(handoff_o)
    );

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge lclk);
        @(negedge lclk);
    endtask

    function automatic logic [24:0] out_cfg();
        return {zctl_o, tc_oe_o, clksel_o, x_thru_n_o, x_fold_n_o,
                y_thru_n_o, y_fold_n_o, z_thru_n_o, z_fold_n_o};
    endfunction

    function automatic logic [24:0] exp_cfg(input logic [19:0] s);
        return {s[19:16], {6{s[15]}}, s[14:10], s[9:0]};
    endfunction

    function automatic logic exp_sdo(input int k, input logic [3:0] bid,
                                     input logic [3:0] lid, input logic pg);
        if (k >= 1 && k <= 4) return bid[4-k];
        if (k >= 5 && k <= 8) return lid[8-k];
        if (k == 9) return pg;
        return 1'b0;
    endfunction

    // R1: reset holds the lines quiet and the outputs at their defaults.
    task automatic t_reset();
        por_n = 1'b0; sys_rst_n = 1'b0; mode_i = 1'b0;
        for (int j = 0; j < 3; j++) begin
            sdi = ~sdi;
            tick();
            check(sdo == 1'b0, "R1 sdo in reset", 32'(sdo), 32'd0);
            check(out_cfg() == DEF_CFG, "R1 defaults in reset",
                  32'(out_cfg()), 32'(DEF_CFG));
        end
    endtask

    // R2..R9: one full exchange, optional mode pause before cycle pause_at.
    task automatic t_exchange(input logic [19:0] s, input logic [3:0] bid,
                              input logic [3:0] lid, input logic pg,
                              input int pause_at);
        board_id_i = bid; logic_id_i = lid; pgood_i = pg;
        t_reset();
        por_n = 1'b1;
        sdi   = 1'b1;
        #1;
        check(sdo == 1'b0, "R2 cycle 0 sdo", 32'(sdo), 32'd0);
        tick();
        for (int k = 1; k <= 21; k++) begin
            if (k == pause_at) begin
                mode_i = 1'b1;
                for (int j = 0; j < 3; j++) begin
                    sdi = ~sdi;
                    #1;
                    check(sdo == 1'b0, "R9 sdo during pause", 32'(sdo), 32'd0);
                    tick();
                end
                mode_i = 1'b0;
            end
            #1;
            if (k <= 4)
                check(sdo == exp_sdo(k, bid, lid, pg), "R3 board id out",
                      32'(sdo), 32'(exp_sdo(k, bid, lid, pg)));
            else if (k == 5)
                check(sdo == exp_sdo(k, bid, lid, pg), "R4 logic id msb out",
                      32'(sdo), 32'(exp_sdo(k, bid, lid, pg)));
            else if (k <= 10)
                check(sdo == exp_sdo(k, bid, lid, pg), "R5 id/pgood out",
                      32'(sdo), 32'(exp_sdo(k, bid, lid, pg)));
            else
                check(sdo == 1'b0, "R8 sdo low late", 32'(sdo), 32'd0);
            sdi = (k <= 20) ? s[20-k] : 1'b1;
            if (k == 21)
                check(out_cfg() == DEF_CFG, "R7 no change before commit",
                      32'(out_cfg()), 32'(DEF_CFG));
            tick();
        end
        check(zctl_o == s[19:16], "R3 zctl", 32'(zctl_o), 32'(s[19:16]));
        check(tc_oe_o == {6{s[15]}}, "R4 test-chip enables",
              32'(tc_oe_o), 32'({6{s[15]}}));
        check(clksel_o == s[14:10], "R5 clksel", 32'(clksel_o), 32'(s[14:10]));
        check({x_thru_n_o, x_fold_n_o, y_thru_n_o, y_fold_n_o,
               z_thru_n_o, z_fold_n_o} == s[9:0], "R6 switch order",
              32'({x_thru_n_o, x_fold_n_o, y_thru_n_o, y_fold_n_o,
                   z_thru_n_o, z_fold_n_o}), 32'(s[9:0]));
    endtask

    // R8, R10: parked behaviour and hand-over flag.
    task automatic t_park(input logic [24:0] held);
        for (int j = 0; j < 6; j++) begin
            sdi = j[0];
            tick();
            check(sdo == 1'b0, "R8 parked sdo", 32'(sdo), 32'd0);
            check(out_cfg() == held, "R8 parked hold", 32'(out_cfg()), 32'(held));
            check(handoff_o == 1'b0, "R10 no handoff in sys reset",
                  32'(handoff_o), 32'd0);
        end
        sys_rst_n = 1'b1;
        #1;
        check(handoff_o == 1'b1, "R10 handoff on release", 32'(handoff_o), 32'd1);
        for (int j = 0; j < 3; j++) begin
            sdi = ~sdi;
            tick();
            check(handoff_o == 1'b1, "R10 handoff held", 32'(handoff_o), 32'd1);
            check(sdo == 1'b0, "R8 sdo after release", 32'(sdo), 32'd0);
            check(out_cfg() == held, "R8 hold after release",
                  32'(out_cfg()), 32'(held));
        end
        sys_rst_n = 1'b0;
        #1;
        check(handoff_o == 1'b0, "R10 handoff drop", 32'(handoff_o), 32'd0);
    endtask

    initial begin
        repeat (20000) @(posedge lclk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [19:0] sa, sb, sc;
        sa = 20'b1010_1_10110_0110100101;
        sb = 20'b0101_0_01001_1001011010;
        sc = 20'b1100_1_00111_1110001011;
        @(negedge lclk);
        t_reset();
        t_exchange(sa, 4'b1001, 4'b0110, 1'b1, 0);
        t_park(exp_cfg(sa));
        t_exchange(sb, 4'b0110, 4'b1001, 1'b0, 7);
        t_park(exp_cfg(sb));
        t_exchange(sc, 4'b0011, 4'b1100, 1'b1, 15);
        t_park(exp_cfg(sc));
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule